// File: doc/BRIEF.md
# Double-Data-Rate Burst-of-Two SRAM Device Model

This block is a synthesizable, cycle-accurate model of the device side of a synchronous SRAM that moves data on both clock edges over a shared data bus, with every access a fixed burst of two words. Both edges of the main clock are modelled as alternate phases of one double-rate clock `clk`. An internal phase bit marks each edge as either the rising edge of K (the "K half") or the rising edge of /K (the "/K half"). The edges of the output clocks are delayed phases of that same clock.

On each K-half edge the model samples a load strobe, a read/write select and an address. A write captures its two data words on the next K-half and /K-half edges. A read drives its two words one phase later than that, on the /C and C edges. When the output clocks are held high, a read falls back to the input-clock edges, one phase earlier. The tri-state data pins appear as a data bus and an output-enable flag. A run input models a stopped clock. While it is low, every edge is frozen out and all state holds.

Top module: `ddr2b_sram`

## Requirements
- R1: While `rstN` is low at an edge, `dqOe` is 0 after that edge, and the first running edge after reset is a K-half edge.
- R2: `ldN`, `rwSel` and `addr` are sampled only on K-half edges. Their values at /K-half edges have no effect on `dq`, `dqOe` or the stored data.
- R3: At a K-half edge, `ldN`=0 with `rwSel`=0 is a write, `ldN`=0 with `rwSel`=1 is a read, and `ldN`=1 is a no-operation whatever `rwSel` is.
- R4: Number the running edges from a command at edge n. A write stores `din` at edge n+2 into the given address, and `din` at edge n+3 into the second burst address.
- R5: With `cHeld`=0, a read shows the word at the given address on `dq` with `dqOe`=1 after edge n+3, and the second burst word after edge n+4.
- R6: The second burst word of any access uses the command address with bit 0 inverted.
- R7: With `cHeld`=1 (output clocks held high), read words appear after edges n+2 and n+3 instead.
- R8: After any running edge that carries no scheduled read word, including edges covered only by no-operations or writes, `dqOe` is 0.
- R9: At an edge where `clkRun` is 0, `dq`, `dqOe`, the phase and the stored data all keep their values.
- R10: A read issued on the K-half edge right after a write to the same address returns the newly written words.
- R11: The phase alternates between K half and /K half on every running edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Double-rate clock; each rising edge is one K-half or /K-half phase |
| rstN | input | 1 | Synchronous active-low reset |
| clkRun | input | 1 | 1 = clocks running; 0 = clocks stopped, edge ignored |
| cHeld | input | 1 | 1 = output clocks held high, read timing taken from the input clocks |
| ldN | input | 1 | Active-low load strobe, sampled on K-half edges |
| rwSel | input | 1 | 1 = read, 0 = write, sampled on K-half edges |
| addr | input | ADDR_W | Word address, sampled on K-half edges |
| din | input | DATA_W | Write data, captured on the two data phases of a write |
| dq | output | DATA_W | Read data |
| dqOe | output | 1 | Output enable; 0 models a high-impedance bus |

## Verification
The hardest state to reach is one where several command pipelines overlap. A write's data phases, the tail of an earlier read and the head of a later read all share the same few edges, and stopped-clock edges fall in the middle of a burst. The stimulus reaches this state with random back-to-back commands on every K half and random garbage on /K halves. It also inserts stopped edges at random points. A schedule in the bench, keyed by running-edge number, predicts each word. Both timing modes are covered, and the bench drains to idle before the mode switches.

// File: rtl/ddr2b_pkg.sv
package ddr2b_pkg;
  parameter int ADDR_W = 4;
  parameter int DATA_W = 18;

  // one command held in the control pipeline
  typedef struct packed {
    logic              valid;
    logic              isWrite;
    logic [ADDR_W-1:0] addr;
  } cmd_t;

  // strobes from control to datapath for the current edge
  typedef struct packed {
    logic              wrEn;
    logic [ADDR_W-1:0] wrAddr;
    logic              rdEn;
    logic [ADDR_W-1:0] rdAddr;
  } strobe_t;
endpackage

// File: rtl/ddr2b_ctrl.sv
module ddr2b_ctrl
  import ddr2b_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkRun,
  input  logic              cHeld,
  input  logic              ldN,
  input  logic              rwSel,
  input  logic [ADDR_W-1:0] addr,
  output logic              phK,
  output strobe_t           stb
);
  localparam logic [ADDR_W-1:0] BURST_FLIP = ADDR_W'(1);

  cmd_t stage1, stage2;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phK    <= 1'b1;
      stage1 <= '0;
      stage2 <= '0;
    end else if (clkRun) begin
      phK <= ~phK;
      if (phK) begin
        stage1 <= '{valid: ~ldN, isWrite: ~rwSel, addr: addr};
        stage2 <= stage1;
      end
    end
  end

  logic s1Rd, s1Wr, s2Rd, s2Wr;
  assign s1Rd = stage1.valid & ~stage1.isWrite;
  assign s1Wr = stage1.valid &  stage1.isWrite;
  assign s2Rd = stage2.valid & ~stage2.isWrite;
  assign s2Wr = stage2.valid &  stage2.isWrite;

  always_comb begin
    stb = '0;
    if (phK) begin
      stb.wrEn   = s1Wr;
      stb.wrAddr = stage1.addr;
      if (cHeld) begin
        stb.rdEn   = s1Rd;
        stb.rdAddr = stage1.addr;
      end else begin
        stb.rdEn   = s2Rd;
        stb.rdAddr = stage2.addr ^ BURST_FLIP;
      end
    end else begin
      stb.wrEn   = s2Wr;
      stb.wrAddr = stage2.addr ^ BURST_FLIP;
      stb.rdEn   = s2Rd;
      stb.rdAddr = cHeld ? (stage2.addr ^ BURST_FLIP) : stage2.addr;
    end
  end
endmodule

// File: rtl/ddr2b_data.sv
module ddr2b_data
  import ddr2b_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkRun,
  input  strobe_t           stb,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dq,
  output logic              dqOe
);
  localparam int DEPTH = 2 ** ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rstN && clkRun && stb.wrEn) mem[stb.wrAddr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      dq   <= '0;
      dqOe <= 1'b0;
    end else if (clkRun) begin
      dqOe <= stb.rdEn;
      if (stb.rdEn) dq <= mem[stb.rdAddr];
    end
  end
endmodule

// File: rtl/ddr2b_sram.sv
module ddr2b_sram
  import ddr2b_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              clkRun,
  input  logic              cHeld,
  input  logic              ldN,
  input  logic              rwSel,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dq,
  output logic              dqOe
);
  strobe_t stb;
  logic    phK;

  ddr2b_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .clkRun(clkRun), .cHeld(cHeld),
    .ldN(ldN), .rwSel(rwSel), .addr(addr), .phK(phK), .stb(stb)
  );

  ddr2b_data u_data (
    .clk(clk), .rstN(rstN), .clkRun(clkRun), .stb(stb),
    .din(din), .dq(dq), .dqOe(dqOe)
  );
endmodule

// File: rtl/ddr2b_chk.sv
module ddr2b_chk
  import ddr2b_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              clkRun,
  input logic              phK,
  input logic [DATA_W-1:0] dq,
  input logic              dqOe
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rstN |=> !dqOe && phK);

  // R11
  phase_toggle_chk: assert property (@(posedge clk) disable iff (!rstN)
    clkRun |=> phK != $past(phK));

  // R9
  stop_oe_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !clkRun |=> $stable(dqOe));

  // R9
  stop_data_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !clkRun |=> $stable(dq) && $stable(phK));
endmodule

bind ddr2b_sram ddr2b_chk u_chk (.*);

// File: tb/sim_ddr2b_sram.sv
`timescale 1ns/1ps
module sim_ddr2b_sram;
  localparam int AW = 4;
  localparam int DW = 18;

  logic clk = 1'b0;
  logic rstN = 1'b0, clkRun = 1'b1, cHeld = 1'b0;
  logic ldN = 1'b1, rwSel = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] din = '0;
  logic [DW-1:0] dq;
  logic dqOe;

  always #10 clk = ~clk;

  ddr2b_sram u0 (.*);

  int checks = 0, errors = 0;
  int edgeNo = 0;
  logic [DW-1:0] refMem [16];
  logic wrV [8]; logic [AW-1:0] wrA [8];
  logic rdV [8]; logic [AW-1:0] rdA [8]; string rdT [8];
  logic expOe = 1'b0; logic [DW-1:0] expDq = '0; string expTag = "R1";

  task automatic check(input bit cond, input string tag, input longint act, input longint exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h (edge %0d)", tag, act, exp, edgeNo);
    end
  endtask

  task automatic clearSched();
    for (int i = 0; i < 8; i++) begin wrV[i] = 0; rdV[i] = 0; end
  endtask

  // one clock edge; reference applied at the edge, outputs checked at negedge
  task automatic step(input bit l, input bit r, input logic [AW-1:0] a, input bit run);
    ldN = l; rwSel = r; addr = a; clkRun = run; din = DW'($urandom);
    @(posedge clk);
    if (run) begin
      int idx = edgeNo % 8;
      if (rdV[idx]) begin
        expOe = 1; expDq = refMem[rdA[idx]]; expTag = rdT[idx];
      end else begin
        expOe = 0; expTag = "R8";
      end
      rdV[idx] = 0;
      if (wrV[idx]) refMem[wrA[idx]] = din;   // R4 capture
      wrV[idx] = 0;
      if (edgeNo % 2 == 0 && !l) begin        // R3 decode, K half only (R2)
        if (!r) begin
          wrV[(edgeNo+2)%8] = 1; wrA[(edgeNo+2)%8] = a;
          wrV[(edgeNo+3)%8] = 1; wrA[(edgeNo+3)%8] = a ^ 4'd1;
        end else begin
          int off = cHeld ? 2 : 3;
          rdV[(edgeNo+off)%8] = 1; rdA[(edgeNo+off)%8] = a;
          rdT[(edgeNo+off)%8] = cHeld ? "R7" : "R5";
          rdV[(edgeNo+off+1)%8] = 1; rdA[(edgeNo+off+1)%8] = a ^ 4'd1;
          rdT[(edgeNo+off+1)%8] = "R6";
        end
      end
      edgeNo++;
    end
    @(negedge clk);
    check(dqOe === expOe, run ? expTag : "R9", dqOe, expOe);
    if (expOe) check(dq === expDq, run ? expTag : "R9", dq, expDq);
  endtask

  // one K cycle: command on the K half, random garbage on the /K half (R2)
  task automatic kcycle(input bit l, input bit r, input logic [AW-1:0] a, input bit stops);
    if (stops && $urandom_range(0, 7) == 0) step($urandom, $urandom, AW'($urandom), 0);
    step(l, r, a, 1);
    if (stops && $urandom_range(0, 7) == 0) step($urandom, $urandom, AW'($urandom), 0);
    step($urandom, $urandom, AW'($urandom), 1);
  endtask

  task automatic flush();
    for (int i = 0; i < 3; i++) kcycle(1, $urandom, AW'($urandom), 0);
  endtask

  task automatic randomRun(input int n);
    for (int i = 0; i < n; i++)
      kcycle($urandom_range(0, 3) == 0, $urandom, AW'($urandom), 1);
  endtask

  initial begin
    void'($urandom(32'd1234));
    clearSched();
    for (int i = 0; i < 16; i++) refMem[i] = '0;
    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(dqOe === 1'b0, "R1", dqOe, 0);
    rstN = 1'b1;
    edgeNo = 0;
    // fill memory with burst writes (R4, R6)
    for (int i = 0; i < 8; i++) kcycle(0, 0, AW'(2*i + (i % 2)), 0);
    flush();
    // R10: write then immediate read of same address, normal timing
    kcycle(0, 0, 4'd5, 0); kcycle(0, 1, 4'd5, 0);
    // back-to-back reads, then NOP with R3 select ignored
    kcycle(0, 1, 4'd2, 0); kcycle(0, 1, 4'd9, 0); kcycle(1, 1, 4'd9, 0);
    flush();
    randomRun(400);
    flush();
    cHeld = 1'b1;                               // R7 fallback timing
    kcycle(0, 0, 4'd12, 0); kcycle(0, 1, 4'd12, 0);   // R10 in fallback
    kcycle(0, 1, 4'd3, 0); kcycle(0, 1, 4'd0, 0);
    flush();
    randomRun(400);
    flush();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule